// File: doc/BRIEF.md
# Write Completion Status Generator

This block supplies the end-of-write signalling for an emulated flash memory. A command decoder pulses `start` on the last write strobe of a command sequence (the fourth strobe for a word program, the sixth for any erase). It also presents the operation kind, the data word being written and the length of the internal operation in clock cycles. From that cycle on, the block runs a loadable countdown timer. While the timer runs, it drives the two polling status bits that a host reads and a ready/busy indication.

The polling bit follows the operation kind. During a program it shows the inverse of the written word's bit 7, and during an erase it shows 0. Once the operation ends it shows the final value. The toggle bit flips once per host read cycle while the operation runs. The ready/busy pin is open-drain. It is modelled as an output enable with a data bit that is always low, and it floats when the chip is deselected or the hardware reset is held.

A hardware reset cuts the operation short and marks it as incomplete. New start requests are dropped while an operation is running.

Top module: `wstat_gen`

## Requirements
- R1: After the synchronous reset `rst`, `busy`, `done`, `rb_oe`, `dq6`, `dq7` and `incomplete` are all 0.
- R2: For a program (`op_erase`=0), `dq7` equals the inverse of `wdata[7]` while `busy` is 1. It equals `wdata[7]` once the operation has completed.
- R3: For an erase (`op_erase`=1), `dq7` is 0 while `busy` is 1 and is 1 once the operation has completed.
- R4: A `start` that is accepted at a clock edge sets `busy` from that edge. `busy` stays set for max(`op_len`,1) cycles. `done` is 1 for exactly one cycle, which is the first cycle with `busy` back at 0.
- R5: While `busy` is 1, `dq6` inverts once for each rising edge of a read cycle, where a read cycle is `rd_en`=1 with `ce_n`=0. It does not change when `busy` is 0 or when `ce_n` is 1.
- R6: `rb_oe` is 1 exactly when `busy` is 1, `ce_n` is 0 and `hard_rst_n` is 1. `rb_lo` is always 0.
- R7: Holding `hard_rst_n` at 0 while `busy` is 1 clears `busy` at the next edge without a `done` pulse and sets `incomplete`. `dq7` then keeps its in-progress value until the next accepted `start`, which clears `incomplete`.
- R8: A `start` is ignored while `busy` is 1 or `hard_rst_n` is 0. The latched operation kind, the data bit and the remaining duration are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| start | input | 1 | One-cycle request issued on the final command strobe |
| op_erase | input | 1 | Operation kind: 1 = erase, 0 = program |
| wdata | input | DW | Word being programmed |
| op_len | input | CW | Internal operation length in clock cycles |
| rd_en | input | 1 | Output-enabled read strobe |
| ce_n | input | 1 | Chip enable, active low |
| hard_rst_n | input | 1 | Hardware reset pin, active low; aborts the operation |
| dq7 | output | 1 | Polling status bit |
| dq6 | output | 1 | Toggle status bit |
| rb_oe | output | 1 | Ready/busy driver enable (pin pulled low when 1) |
| rb_lo | output | 1 | Ready/busy driven level, always 0 |
| busy | output | 1 | Internal operation running |
| done | output | 1 | One-cycle completion pulse |
| incomplete | output | 1 | Last operation was cut short by the hardware reset |

## Verification
The bench measures the busy window to the exact cycle, including the zero-length case. A design that counted one cycle too many or too few, or treated a zero length as a very long one, would move the `done` pulse away from the checked cycle. Toggle reads are issued with the chip deselected and after completion, so a toggle that ran off the clock or off any strobe would flip when it must hold. A second `start` arrives during a program with a different kind and length, and a hardware reset hits an erase in flight. A design that accepted the second request or reported a clean finish after the reset would show the wrong `dq7`, a shortened busy window, or a stray `done`.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     tbit;
    } op_ctx_t;

    // Polling bit: pending selects the in-progress view.
    function automatic logic poll_bit(op_ctx_t c, logic pending);
        logic r;
        if (c.kind == OP_ERASE)
            r = ~pending;
        else
            r = pending ? ~c.tbit : c.tbit;
        return r;
    endfunction

endpackage

// File: rtl/wstat_timer.sv
module wstat_timer #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    input  logic          abort,
    output logic          running,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (abort) begin
                running <= 1'b0;
                cnt     <= '0;
            end else if (load) begin
                running <= 1'b1;
                cnt     <= len;
            end else if (running) begin
                if (cnt <= ONE) begin
                    running <= 1'b0;
                    expire  <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    // R4
    expire_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        expire |-> (!running && $past(running)));

    // R4
    load_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !abort) |=> running);

    // R4
    run_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !abort && cnt > ONE) |=> (running && !expire));

    // R7
    abort_no_expire_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!running && !expire));

endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  logic ce_n,
    input  logic busy,
    output logic q6
);
    logic rd_q;
    logic rd_act;
    logic rd_rise;

    assign rd_act  = rd_en & ~ce_n;
    assign rd_rise = rd_act & ~rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            q6   <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (busy && rd_rise)
                q6 <= ~q6;
        end
    end

    // R5
    tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en && !ce_n && !rd_q) |=> (q6 != $past(q6)));

    // R5
    tog_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || ce_n) |=> $stable(q6));

endmodule

// File: rtl/wstat_ctrl.sv
module wstat_ctrl
    import wstat_pkg::*;
#(
    parameter int DW       = 16,
    parameter int POLL_IDX = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_erase,
    input  logic [DW-1:0] wdata,
    input  logic          hard_rst_n,
    input  logic          running,
    output logic          load,
    output logic          abort,
    output op_ctx_t       ctx,
    output logic          incomplete
);
    assign abort = ~hard_rst_n;
    assign load  = start & ~running & hard_rst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx        <= '{kind: OP_PROG, tbit: 1'b0};
            incomplete <= 1'b0;
        end else begin
            if (load) begin
                ctx.kind   <= op_erase ? OP_ERASE : OP_PROG;
                ctx.tbit   <= wdata[POLL_IDX];
                incomplete <= 1'b0;
            end else if (abort && running) begin
                incomplete <= 1'b1;
            end
        end
    end

    // R8
    ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && running) |=> $stable(ctx));

    // R8
    ignore_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !hard_rst_n) |=> $stable(ctx));

    // R7
    abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!hard_rst_n && running) |=> incomplete);

endmodule

// File: rtl/wstat_gen.sv
module wstat_gen
    import wstat_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CW       = 24,
    parameter int POLL_IDX = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_erase,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] op_len,
    input  logic          rd_en,
    input  logic          ce_n,
    input  logic          hard_rst_n,
    output logic          dq7,
    output logic          dq6,
    output logic          rb_oe,
    output logic          rb_lo,
    output logic          busy,
    output logic          done,
    output logic          incomplete
);
    logic    load;
    logic    abort;
    logic    running;
    logic    expire;
    op_ctx_t ctx;

    wstat_ctrl #(.DW(DW), .POLL_IDX(POLL_IDX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_erase   (op_erase),
        .wdata      (wdata),
        .hard_rst_n (hard_rst_n),
        .running    (running),
        .load       (load),
        .abort      (abort),
        .ctx        (ctx),
        .incomplete (incomplete)
    );

    wstat_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .len     (op_len),
        .abort   (abort),
        .running (running),
        .expire  (expire)
    );

    wstat_toggle u_tog (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .ce_n  (ce_n),
        .busy  (running),
        .q6    (dq6)
    );

    assign busy  = running;
    assign done  = expire;
    assign dq7   = poll_bit(ctx, running | incomplete);
    assign rb_oe = running & ~ce_n & hard_rst_n;
    assign rb_lo = 1'b0;

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !hard_rst_n |=> (!busy && !done));

    // R6
    rb_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rb_oe |-> (busy && !rb_lo));

    // R3
    erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ctx.kind == OP_ERASE) |-> !dq7);

endmodule

// File: tb/wstat_gen_test.sv
`timescale 1ns/1ps
module wstat_gen_test;

    logic        clk = 1'b0;
    logic        rst, start, op_erase, rd_en, ce_n, hard_rst_n;
    logic [15:0] wdata;
    logic [23:0] op_len;
    logic        dq7, dq6, rb_oe, rb_lo, busy, done, incomplete;

    always #4 clk = ~clk;

    wstat_gen uut (
        .clk(clk), .rst(rst), .start(start), .op_erase(op_erase),
        .wdata(wdata), .op_len(op_len), .rd_en(rd_en), .ce_n(ce_n),
        .hard_rst_n(hard_rst_n), .dq7(dq7), .dq6(dq6), .rb_oe(rb_oe),
        .rb_lo(rb_lo), .busy(busy), .done(done), .incomplete(incomplete)
    );

    localparam int S_BUSY = 0, S_DQ7 = 1, S_DQ6 = 2, S_RBOE = 3,
                   S_DONE = 4, S_INC = 5, S_RBLO = 6;

    typedef struct {
        string tag;
        int    sel;
        logic  exp;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    bad   = 0;
    bit    ended = 0;
    logic  q6_exp = 1'b0;
    event  smp;

    function automatic logic pick(int s);
        case (s)
            S_BUSY:  return busy;
            S_DQ7:   return dq7;
            S_DQ6:   return dq6;
            S_RBOE:  return rb_oe;
            S_DONE:  return done;
            S_INC:   return incomplete;
            default: return rb_lo;
        endcase
    endfunction

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(smp);
            while (sb.size() > 0) begin
                item_t it;
                logic  act;
                it  = sb.pop_front();
                act = pick(it.sel);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %b exp %b", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_(string tag, int sel, logic e);
        sb.push_back('{tag, sel, e});
    endtask

    task automatic flush;
        ->smp;
        #1;
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic do_start(logic er, logic [15:0] d, logic [23:0] n);
        start = 1'b1; op_erase = er; wdata = d; op_len = n;
        tick;
        start = 1'b0;
    endtask

    task automatic rd_pulse;
        rd_en = 1'b1;
        tick;
        rd_en = 1'b0;
        tick;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            tick;
        end
    endtask

    task automatic finish_run;
        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp finished run");
            finish_run;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_erase = 1'b0; rd_en = 1'b0;
        ce_n = 1'b0; hard_rst_n = 1'b1; wdata = '0; op_len = '0;
        repeat (3) tick;
        rst = 1'b0;
        tick;
        // R1 reset state
        expect_("R1 busy", S_BUSY, 1'b0);
        expect_("R1 done", S_DONE, 1'b0);
        expect_("R1 rb_oe", S_RBOE, 1'b0);
        expect_("R1 dq6", S_DQ6, 1'b0);
        expect_("R1 dq7", S_DQ7, 1'b0);
        expect_("R1 incomplete", S_INC, 1'b0);
        expect_("R6 rb_lo", S_RBLO, 1'b0);
        flush;

        // R4 exact duration of a 5-cycle program, R2 polling bit
        do_start(1'b0, 16'h0080, 24'd5);
        expect_("R4 busy c1", S_BUSY, 1'b1);
        expect_("R2 dq7 inverted", S_DQ7, 1'b0);
        expect_("R6 rb_oe busy", S_RBOE, 1'b1);
        expect_("R4 no early done", S_DONE, 1'b0);
        flush;
        for (int i = 2; i <= 5; i++) begin
            tick;
            expect_("R4 busy held", S_BUSY, 1'b1);
            expect_("R4 done low while busy", S_DONE, 1'b0);
            flush;
        end
        tick;
        expect_("R4 busy ends", S_BUSY, 1'b0);
        expect_("R4 done pulse", S_DONE, 1'b1);
        expect_("R2 dq7 true", S_DQ7, 1'b1);
        expect_("R6 rb_oe released", S_RBOE, 1'b0);
        flush;
        tick;
        expect_("R4 done one cycle", S_DONE, 1'b0);
        flush;

        // R4 zero length behaves as one cycle
        do_start(1'b0, 16'h0000, 24'd0);
        expect_("R4 len0 busy", S_BUSY, 1'b1);
        flush;
        tick;
        expect_("R4 len0 ends", S_BUSY, 1'b0);
        expect_("R4 len0 done", S_DONE, 1'b1);
        expect_("R2 dq7 true zero", S_DQ7, 1'b0);
        flush;
        tick;

        // R5 toggle during a long program with bit 7 = 0
        do_start(1'b0, 16'h7F7F, 24'd40);
        expect_("R2 dq7 inverted of 0", S_DQ7, 1'b1);
        flush;
        for (int i = 0; i < 3; i++) begin
            rd_pulse;
            q6_exp = ~q6_exp;
            expect_("R5 dq6 flips on read", S_DQ6, q6_exp);
            flush;
        end
        ce_n = 1'b1;
        #1;
        expect_("R6 rb_oe floats ce_n high", S_RBOE, 1'b0);
        flush;
        rd_pulse;
        expect_("R5 no flip deselected", S_DQ6, q6_exp);
        flush;
        ce_n = 1'b0;
        #1;
        expect_("R6 rb_oe back", S_RBOE, 1'b1);
        flush;
        // R8 second start ignored while busy
        do_start(1'b1, 16'hFFFF, 24'd2);
        expect_("R8 still busy", S_BUSY, 1'b1);
        expect_("R8 kind kept", S_DQ7, 1'b1);
        flush;
        repeat (3) tick;
        expect_("R8 length kept", S_BUSY, 1'b1);
        expect_("R8 no early done", S_DONE, 1'b0);
        flush;
        wait_idle;
        expect_("R4 done after program", S_DONE, 1'b1);
        expect_("R2 dq7 true after", S_DQ7, 1'b0);
        flush;
        rd_pulse;
        expect_("R5 dq6 stable idle", S_DQ6, q6_exp);
        flush;

        // R3 erase polling
        do_start(1'b1, 16'h00FF, 24'd8);
        expect_("R3 dq7 zero busy", S_DQ7, 1'b0);
        flush;
        rd_pulse;
        q6_exp = ~q6_exp;
        expect_("R5 dq6 flips erase", S_DQ6, q6_exp);
        flush;
        wait_idle;
        expect_("R3 dq7 one after", S_DQ7, 1'b1);
        expect_("R4 erase done", S_DONE, 1'b1);
        expect_("R7 complete flag", S_INC, 1'b0);
        flush;
        tick;

        // R7 hardware reset aborts an erase
        do_start(1'b1, 16'h0000, 24'd50);
        repeat (2) tick;
        hard_rst_n = 1'b0;
        #1;
        expect_("R6 rb_oe floats in reset", S_RBOE, 1'b0);
        flush;
        tick;
        expect_("R7 busy cleared", S_BUSY, 1'b0);
        expect_("R7 no done", S_DONE, 1'b0);
        expect_("R7 incomplete set", S_INC, 1'b1);
        expect_("R7 dq7 stays 0", S_DQ7, 1'b0);
        flush;
        // R8 start ignored while hard reset held
        do_start(1'b0, 16'h0080, 24'd3);
        expect_("R8 ignored in reset", S_BUSY, 1'b0);
        expect_("R8 flag kept", S_INC, 1'b1);
        flush;
        hard_rst_n = 1'b1;
        repeat (3) tick;
        expect_("R7 idle after release", S_BUSY, 1'b0);
        expect_("R7 dq7 incomplete", S_DQ7, 1'b0);
        expect_("R7 no late done", S_DONE, 1'b0);
        flush;
        do_start(1'b0, 16'h0080, 24'd3);
        expect_("R7 new start clears", S_INC, 1'b0);
        expect_("R2 dq7 inv after abort", S_DQ7, 1'b0);
        flush;
        wait_idle;
        expect_("R2 dq7 final", S_DQ7, 1'b1);
        expect_("R4 done final", S_DONE, 1'b1);
        flush;
        tick;
        finish_run;
    end

endmodule